// File: doc/BRIEF.md
# Floating-Cell Level Selector for One Hybrid Inverter Phase

This block drives the four main switches of one phase of a hybrid five-level leg. One winding end is fed by a bus-fed two-level leg, called the near leg. The other end is fed by a second bus-fed two-level leg, called the far leg. A two-leg H-bridge, called the cell, sits in series with the winding and carries a floating capacitor. A modulator supplies a signed level code from −2 to +2 once per switching period. The block turns that code into gate bits. The two bus legs each contribute a step of two units, and the cell contributes a step of one unit.

Levels ±1 can be reached in two ways. In one the cell adds to the winding voltage, and in the other it subtracts from it. The block uses the sign of the phase current and a capacitor-high flag to pick the way that pushes the capacitor voltage back toward its target. All other levels keep the cell in bypass. A clamp input covers a failed cell: it keeps the cell in bypass and runs the phase as a three-level leg. Codes outside the legal range force every gate off and raise an error flag. Each new choice is taken only at the period strobe and is held until the next one.

Top module: `cell_level_sel`

## Requirements
- R1: While `rst` is high, and after it falls until the first strobe, `gate_o` is 0000 and `err_o` is 0.
- R2: `gate_o[0]` drives the near bus leg, `gate_o[1]` drives cell leg A, `gate_o[2]` drives cell leg B and `gate_o[3]` drives the far bus leg. The winding level they produce is 2·(g0−g3) + (g2−g1). For a legal unclamped code, this level equals the code, which is `lvl_i` read as 3-bit two's complement.
- R3: Codes +2, 0 and −2 keep the cell in bypass (g1 = g2 = 0). They give 0001, 0000 and 1000 respectively, written as {g3,g2,g1,g0}.
- R4: For codes ±1, a charge is wanted when `cap_hi_i` = 0. The cell steps against the current (cell term −1) exactly when the wanted charge equals `i_pos_i`, and steps with it (+1) otherwise. This gives +1 as 0011 or 0100, and −1 as 0010 or 1100 ({g3..g0}). The capacitor then charges exactly when `cap_hi_i` = 0.
- R5: The patterns for ±3 (0101 and 1010) never appear on `gate_o`.
- R6: `gate_o` and `err_o` take new values only at the clock edge that ends a cycle with `stb_i` high. At every other edge they hold, whatever the other inputs do.
- R7: When `clamp_i` is high at a strobe and the code is legal, the cell stays in bypass. Codes ±1 give 0000, and ±2 and 0 behave as in R3. `err_o` is 0.
- R8: An illegal code (+3, −3 or −4) at a strobe gives `gate_o` = 0000 and `err_o` = 1, even when `clamp_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_i | input | 3 | Commanded level, two's complement |
| i_pos_i | input | 1 | Phase current sign, 1 = positive |
| cap_hi_i | input | 1 | Floating capacitor above target |
| stb_i | input | 1 | Switching-period strobe |
| clamp_i | input | 1 | Cell fault: hold cell in bypass |
| gate_o | output | 4 | Main gate bits {far, cellB, cellA, near} |
| err_o | output | 1 | Illegal level code latched |

## Verification
The hardest case to produce at the ports is a change of current sign, capacitor flag, clamp or code between two strobes. Such a change must leave the gates untouched until the next strobe. To reach it, each strobe in the stimulus is followed by quiet cycles in which every other input is toggled. Alongside that, an exhaustive sweep strobes all 64 combinations of code, current sign, flag and clamp. A long pseudo-random phase then mixes irregular strobe spacing with the same input changes.

// File: rtl/cell_level_pkg.sv
package cell_level_pkg;
  localparam int GATE_N   = 4;
  localparam int G_NEAR   = 0;
  localparam int G_CELL_A = 1;
  localparam int G_CELL_B = 2;
  localparam int G_FAR    = 3;
  typedef logic [GATE_N-1:0] gate_t;
endpackage

// File: rtl/cl_decode.sv
module cl_decode #(
  parameter int LVL_W = 3
) (
  input  logic [LVL_W-1:0] lvl,
  output logic             legal,
  output logic             odd,
  output logic             neg,
  output logic             full
);
  localparam logic signed [LVL_W-1:0] LV_HI = LVL_W'(2);
  localparam logic signed [LVL_W-1:0] LV_LO = -LV_HI;
  logic signed [LVL_W-1:0] s;

  always_comb begin
    s     = $signed(lvl);
    legal = (s <= LV_HI) && (s >= LV_LO);
    odd   = s[0];
    neg   = s[LVL_W-1];
    full  = (s == LV_HI) || (s == LV_LO);
  end
endmodule

// File: rtl/cl_pick.sv
module cl_pick
  import cell_level_pkg::*;
(
  input  logic  legal,
  input  logic  odd,
  input  logic  neg,
  input  logic  full,
  input  logic  i_pos,
  input  logic  cap_hi,
  input  logic  clamp,
  output gate_t gate_d,
  output logic  err_d
);
  logic want_chg;
  logic against;

  always_comb begin
    want_chg = ~cap_hi;
    against  = (want_chg == i_pos);
    gate_d   = '0;
    err_d    = 1'b0;
    if (!legal) begin
      err_d = 1'b1;
    end else if (full) begin
      gate_d[G_NEAR] = ~neg;
      gate_d[G_FAR]  = neg;
    end else if (odd && !clamp) begin
      if (against) begin
        gate_d[G_CELL_A] = 1'b1;
        gate_d[G_NEAR]   = ~neg;
      end else begin
        gate_d[G_CELL_B] = 1'b1;
        gate_d[G_FAR]    = neg;
      end
    end
  end
endmodule

// File: rtl/cl_hold.sv
module cl_hold
  import cell_level_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  stb,
  input  gate_t gate_d,
  input  logic  err_d,
  output gate_t gate_q,
  output logic  err_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= '0;
      err_q  <= 1'b0;
    end else if (stb) begin
      gate_q <= gate_d;
      err_q  <= err_d;
    end
  end

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    !stb |=> ($stable(gate_q) && $stable(err_q))); // R6
endmodule

// File: rtl/cell_level_sel.sv
module cell_level_sel
  import cell_level_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             i_pos_i,
  input  logic             cap_hi_i,
  input  logic             stb_i,
  input  logic             clamp_i,
  output logic [3:0]       gate_o,
  output logic             err_o
);
  localparam logic signed [LVL_W-1:0] CHK_HI = LVL_W'(2);
  localparam logic signed [LVL_W-1:0] CHK_LO = -CHK_HI;

  logic  legal, odd, neg, full, err_d;
  gate_t gate_d, gate_q;

  cl_decode #(.LVL_W(LVL_W)) dec_i (
    .lvl(lvl_i), .legal(legal), .odd(odd), .neg(neg), .full(full)
  );

  cl_pick pick_i (
    .legal(legal), .odd(odd), .neg(neg), .full(full),
    .i_pos(i_pos_i), .cap_hi(cap_hi_i), .clamp(clamp_i),
    .gate_d(gate_d), .err_d(err_d)
  );

  cl_hold hold_i (
    .clk(clk), .rst(rst), .stb(stb_i),
    .gate_d(gate_d), .err_d(err_d),
    .gate_q(gate_q), .err_q(err_o)
  );

  assign gate_o = gate_q;

  AST_NO_TRIPLE: assert property (@(posedge clk) disable iff (rst)
    (gate_o != 4'b0101) && (gate_o != 4'b1010)); // R5

  AST_BAD_SAFE: assert property (@(posedge clk) disable iff (rst)
    (stb_i && (($signed(lvl_i) > CHK_HI) || ($signed(lvl_i) < CHK_LO)))
    |=> (gate_o == 4'b0000) && err_o); // R8

  AST_CLAMP_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (stb_i && clamp_i) |=> !gate_o[1] && !gate_o[2]); // R7

  AST_EVEN_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (stb_i && !lvl_i[0]) |=> !gate_o[1] && !gate_o[2]); // R3
endmodule

// File: tb/cell_level_sel_tb.sv
module cell_level_sel_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] lvl = 3'd0;
  logic       ipos = 1'b0, caphi = 1'b0, stb = 1'b0, clamp = 1'b0;
  logic [3:0] gate_o;
  logic       err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0] m_gate = 4'd0;
  logic       m_err = 1'b0;
  string      m_tag = "R1";
  int         m_lvl = 0;
  bit         m_odd = 1'b0;
  bit         m_chg = 1'b0;
  bit         m_ipos = 1'b0;

  always #2.5 clk = ~clk;

  cell_level_sel dut_i (
    .clk(clk), .rst(rst), .lvl_i(lvl), .i_pos_i(ipos), .cap_hi_i(caphi),
    .stb_i(stb), .clamp_i(clamp), .gate_o(gate_o), .err_o(err_o)
  );

  function automatic int lvl_of(logic [3:0] g);
    return 2 * (int'(g[0]) - int'(g[3])) + (int'(g[2]) - int'(g[1]));
  endfunction

  function automatic int cell_of(logic [3:0] g);
    return int'(g[2]) - int'(g[1]);
  endfunction

  // Search all 16 patterns for the fewest-gates match of level and cell term.
  function automatic logic [3:0] ref_pick(int lv, bit ip, bit ch, bit cl);
    int want_lv, want_cell, best_pop;
    logic [3:0] best;
    want_lv = lv;
    want_cell = 0;
    if (lv == 1 || lv == -1) begin
      if (cl) want_lv = 0;
      else want_cell = ((!ch) == ip) ? -1 : 1;
    end
    best = 4'd0;
    best_pop = 99;
    for (int p = 0; p < 16; p++) begin
      logic [3:0] g;
      g = 4'(p);
      if (lvl_of(g) == want_lv && cell_of(g) == want_cell && $countones(g) < best_pop) begin
        best = g;
        best_pop = $countones(g);
      end
    end
    return best;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_gate <= 4'd0; m_err <= 1'b0; m_tag <= "R1"; m_odd <= 1'b0;
    end else if (stb) begin
      int v;
      v = int'($signed(lvl));
      m_lvl  <= v;
      m_ipos <= ipos;
      m_chg  <= !caphi;
      m_odd  <= 1'b0;
      if (v > 2 || v < -2) begin
        m_gate <= 4'd0; m_err <= 1'b1; m_tag <= "R8";
      end else begin
        m_gate <= ref_pick(v, ipos, caphi, clamp);
        m_err  <= 1'b0;
        if (clamp) m_tag <= "R7";
        else if (v == 1 || v == -1) begin m_tag <= "R4"; m_odd <= 1'b1; end
        else m_tag <= "R3";
      end
    end else if (m_tag != "R1") begin
      m_tag <= "R6";
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(gate_o == m_gate, m_tag, "gate_o", int'(gate_o), int'(m_gate));
      chk(err_o == m_err, m_tag, "err_o", int'(err_o), int'(m_err));
      chk(gate_o != 4'b0101 && gate_o != 4'b1010, "R5", "triple level", int'(gate_o), 0);
      if (m_odd && m_tag != "R6") begin
        int eff;
        eff = -cell_of(gate_o) * (m_ipos ? 1 : -1);
        chk(lvl_of(gate_o) == m_lvl, "R2", "winding level", lvl_of(gate_o), m_lvl);
        chk((eff > 0) == m_chg, "R4", "charge direction", eff, m_chg ? 1 : -1);
      end
    end
  end

  task automatic tick();
    @(negedge clk); #0.5;
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    repeat (2) tick();
    for (int v = -4; v < 4; v++)
      for (int ip = 0; ip < 2; ip++)
        for (int ch = 0; ch < 2; ch++)
          for (int cl = 0; cl < 2; cl++) begin
            lvl = 3'(v); ipos = ip[0]; caphi = ch[0]; clamp = cl[0]; stb = 1'b1;
            tick();
            stb = 1'b0;
            ipos = ~ipos; caphi = ~caphi; clamp = ~clamp; lvl = lvl + 3'd1;
            tick();
            lvl = 3'd3;
            tick();
            tick();
          end
    for (int i = 0; i < 3000; i++) begin
      lvl = 3'($urandom_range(0, 7));
      ipos = 1'($urandom); caphi = 1'($urandom); clamp = ($urandom_range(0, 3) == 0);
      stb = ($urandom_range(0, 2) == 0);
      tick();
    end
    stb = 1'b0;
    repeat (3) tick();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule